// File: doc/BRIEF.md
# Video Byte Stream Formatter

This block takes one processed pixel at a time and turns it into an 8-bit parallel video stream with a pixel clock, a line-valid strobe and a frame-valid strobe. Each pixel becomes two bytes on the bus. The byte content depends on the selected output family:
- YCbCr 4:2:2 with separate syncs, in one of four component orders.
- RGB565, with either red or blue in the first byte.
- 10-bit raw sensor data, split into a padded high byte and a low byte.
- YCbCr with embedded timing reference codes.

Colour conversion, scaling and tone curves happen upstream. This block only picks, orders and frames the bytes.

An upstream source pulses `frame_start` to open a frame and then pulses `line_start` once per active line. After each `line_start` the block spends four byte slots on a lead-in and then expects one pixel on every second clock. When the line is done it spends four slots on a tail. The control FSM has four states:
- IDLE: blanking.
- LEAD: four-cycle lead-in.
- ACTIVE: pixel bytes.
- TRAIL: four-cycle tail.

The transitions are:
- IDLE to LEAD on an accepted `line_start`.
- LEAD to ACTIVE after its fourth cycle.
- ACTIVE to TRAIL after the second byte of the last pixel.
- TRAIL to IDLE after its fourth cycle. The frame closes at this point when the line was the last one.

Top module: `vfmt_out`

## Requirements
- R1: While `rst_n` is low, `vid_data` is 00, `vid_hsync` is 0 and `vid_vsync` is 0. After reset the latched format is separate-sync YCbCr.
- R2: A `frame_start` pulse seen with `vid_vsync` low raises `vid_vsync` in the next cycle and latches `cfg_fmt` and `cfg_ord`. While `vid_vsync` is high, both `frame_start` and any change to `cfg_fmt`/`cfg_ord` have no effect on the output bytes or on the frame length.
- R3: If `line_start` is sampled at clock edge E0 while in a frame and idle, the cycles after E0..E3 are the lead-in with hsync low. `vid_hsync` is high for the 2*H_ACTIVE cycles after E4..E(3+2*H_ACTIVE). The following four cycles are the tail with hsync low.
- R4: Pixel k is sampled at edge E(4+2k). Its two bytes appear in the cycles after E(4+2k) and E(5+2k).
- R5: With `cfg_fmt`=0 (separate-sync YCbCr), the four bytes of an even/odd pixel pair follow `cfg_ord`: 0 gives Cb Y0 Cr Y1, 1 gives Cr Y0 Cb Y1, 2 gives Y0 Cb Y1 Cr, and 3 gives Y0 Cr Y1 Cb. Both Cb and Cr are taken from the even pixel, and data bytes 00 and FF pass unchanged.
- R6: With `cfg_fmt`=2 (RGB565) and `cfg_ord[0]`=0, a pixel is sent as {R[4:0],G[5:3]} then {G[2:0],B[4:0]}. With `cfg_ord[0]`=1 it is sent as {B[4:0],G[5:3]} then {G[2:0],R[4:0]}.
- R7: With `cfg_fmt`=3 (raw), a sample is sent as {6'b0,D[9:8]} then D[7:0].
- R8: With `cfg_fmt`=1 (embedded codes), the lead-in bytes are FF 00 00 80 and the tail bytes are FF 00 00 9D. The code byte is {1,F=0,V=0,H,V^H,F^H,F^V,F^V^H}. Data always uses the Cb Y0 Cr Y1 order, and data bytes 00 and FF are sent as 01 and FE.
- R9: Outside hsync, formats 0, 2 and 3 drive 00. In format 1, idle cycles alternate 80 and 10, beginning with 80 on the first idle cycle after a line tail.
- R10: `vid_vsync` falls at the edge that ends the tail of line V_ACTIVE. A `line_start` seen while `vid_vsync` is low is ignored.
- R11: `vid_pclk` is the inverse of `clk`, so the bus changes on the falling edge of `vid_pclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Frame open pulse |
| line_start | input | 1 | Line open pulse |
| pix_valid | input | 1 | Pixel strobe |
| pix_y | input | 8 | Luma |
| pix_cb | input | 8 | Blue chroma |
| pix_cr | input | 8 | Red chroma |
| pix_r | input | 5 | Red, 5 bits |
| pix_g | input | 6 | Green, 6 bits |
| pix_b | input | 5 | Blue, 5 bits |
| pix_raw | input | 10 | Raw sensor sample |
| cfg_fmt | input | 2 | Output family: 0 separate-sync YCbCr, 1 embedded codes, 2 RGB565, 3 raw |
| cfg_ord | input | 2 | Byte order select |
| vid_data | output | 8 | Output byte |
| vid_hsync | output | 1 | Line-valid strobe |
| vid_vsync | output | 1 | Frame-valid strobe |
| vid_pclk | output | 1 | Pixel clock |

## Verification
The assertions check rules that hold on every cycle:
- hsync only inside vsync;
- a format that never changes inside a frame;
- no 00 or FF among embedded-code data bytes;
- zero blanking in the separate-sync families;
- the zero pad on the raw high byte;
- the 80/10 alternation while idle.

Only the bench's scenarios can show the rest:
- the exact cycle at which the lead-in, pixel bytes and tail fall;
- each of the four component orders and both RGB byte orders;
- the code bytes themselves;
- that frame and config pokes made in mid-frame are ignored.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;

    localparam int BYTE_W = 8;
    localparam int RAW_W  = 10;
    localparam int R_W    = 5;
    localparam int G_W    = 6;
    localparam int B_W    = 5;
    localparam int GAP_CYC = 4;

    localparam logic [BYTE_W-1:0] BLANK_LO = 8'h80;
    localparam logic [BYTE_W-1:0] BLANK_HI = 8'h10;

    typedef enum logic [1:0] {
        FMT_601 = 2'd0,
        FMT_656 = 2'd1,
        FMT_RGB = 2'd2,
        FMT_RAW = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_ACT   = 2'd2,
        ST_TRAIL = 2'd3
    } st_e;

    // Timing reference code byte with protection bits
    function automatic logic [BYTE_W-1:0] trs_code(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

endpackage

// File: rtl/vfmt_seq.sv
module vfmt_seq
    import vfmt_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int V_ACTIVE = 480
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       line_start,
    input  logic [1:0] cfg_fmt,
    input  logic [1:0] cfg_ord,
    output st_e        st,
    output logic [1:0] cnt,
    output logic       ph,
    output logic       pix_odd,
    output logic       in_frame,
    output fmt_e       fmt_q,
    output logic [1:0] ord_q
);

    localparam int PW = $clog2(H_ACTIVE + 1);
    localparam int LW = $clog2(V_ACTIVE + 1);
    localparam logic [PW-1:0] PIX_LAST  = PW'(H_ACTIVE - 1);
    localparam logic [LW-1:0] LINE_LAST = LW'(V_ACTIVE - 1);
    localparam logic [1:0]    GAP_LAST  = 2'(GAP_CYC - 1);

    st_e           st_nx;
    logic [1:0]    cnt_nx;
    logic          ph_nx;
    logic [PW-1:0] pix_q, pix_nx;
    logic [LW-1:0] line_q, line_nx;
    logic          frm_nx;
    fmt_e          fmt_nx;
    logic [1:0]    ord_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            ph       <= 1'b0;
            pix_q    <= '0;
            line_q   <= '0;
            in_frame <= 1'b0;
            fmt_q    <= FMT_601;
            ord_q    <= '0;
        end else begin
            st       <= st_nx;
            cnt      <= cnt_nx;
            ph       <= ph_nx;
            pix_q    <= pix_nx;
            line_q   <= line_nx;
            in_frame <= frm_nx;
            fmt_q    <= fmt_nx;
            ord_q    <= ord_nx;
        end
    end

    // Transitions
    always_comb begin
        st_nx   = st;
        cnt_nx  = cnt;
        ph_nx   = ph;
        pix_nx  = pix_q;
        line_nx = line_q;
        frm_nx  = in_frame;
        fmt_nx  = fmt_q;
        ord_nx  = ord_q;
        unique case (st)
            ST_IDLE: begin
                ph_nx = ~ph;
                if (!in_frame && frame_start) begin
                    frm_nx  = 1'b1;
                    line_nx = '0;
                    fmt_nx  = fmt_e'(cfg_fmt);
                    ord_nx  = cfg_ord;
                end else if (in_frame && line_start) begin
                    st_nx  = ST_LEAD;
                    cnt_nx = '0;
                end
            end
            ST_LEAD: begin
                cnt_nx = cnt + 2'd1;
                if (cnt == GAP_LAST) begin
                    st_nx  = ST_ACT;
                    ph_nx  = 1'b0;
                    pix_nx = '0;
                end
            end
            ST_ACT: begin
                ph_nx = ~ph;
                if (ph) begin
                    pix_nx = pix_q + 1'b1;
                    if (pix_q == PIX_LAST) begin
                        st_nx  = ST_TRAIL;
                        cnt_nx = '0;
                    end
                end
            end
            ST_TRAIL: begin
                cnt_nx = cnt + 2'd1;
                if (cnt == GAP_LAST) begin
                    st_nx   = ST_IDLE;
                    ph_nx   = 1'b0;
                    line_nx = line_q + 1'b1;
                    if (line_q == LINE_LAST) frm_nx = 1'b0;
                end
            end
        endcase
    end

    assign pix_odd = pix_q[0];

endmodule

// File: rtl/vfmt_hold.sv
module vfmt_hold
    import vfmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  st_e              st,
    input  logic             pix_valid,
    input  logic [BYTE_W-1:0] pix_y,
    input  logic [BYTE_W-1:0] pix_cb,
    input  logic [BYTE_W-1:0] pix_cr,
    input  logic [R_W-1:0]   pix_r,
    input  logic [G_W-1:0]   pix_g,
    input  logic [B_W-1:0]   pix_b,
    input  logic [RAW_W-1:0] pix_raw,
    output logic [BYTE_W-1:0] y_q,
    output logic [BYTE_W-1:0] cb_q,
    output logic [BYTE_W-1:0] cr_q,
    output logic [R_W-1:0]   r_q,
    output logic [G_W-1:0]   g_q,
    output logic [B_W-1:0]   b_q,
    output logic [RAW_W-1:0] raw_q
);

    logic odd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            odd_q <= 1'b0;
            y_q   <= '0;
            cb_q  <= '0;
            cr_q  <= '0;
            r_q   <= '0;
            g_q   <= '0;
            b_q   <= '0;
            raw_q <= '0;
        end else if (pix_valid) begin
            odd_q <= ~odd_q;
            y_q   <= pix_y;
            r_q   <= pix_r;
            g_q   <= pix_g;
            b_q   <= pix_b;
            raw_q <= pix_raw;
            if (!odd_q) begin
                cb_q <= pix_cb;
                cr_q <= pix_cr;
            end
        end else if (st == ST_LEAD) begin
            odd_q <= 1'b0;
        end
    end

endmodule

// File: rtl/vfmt_bytesel.sv
module vfmt_bytesel
    import vfmt_pkg::*;
(
    input  st_e              st,
    input  logic [1:0]       cnt,
    input  logic             ph,
    input  logic             pix_odd,
    input  fmt_e             fmt_q,
    input  logic [1:0]       ord_q,
    input  logic [BYTE_W-1:0] y_q,
    input  logic [BYTE_W-1:0] cb_q,
    input  logic [BYTE_W-1:0] cr_q,
    input  logic [R_W-1:0]   r_q,
    input  logic [G_W-1:0]   g_q,
    input  logic [B_W-1:0]   b_q,
    input  logic [RAW_W-1:0] raw_q,
    output logic [BYTE_W-1:0] dout
);

    logic [1:0]        slot;
    logic [1:0]        yord;
    logic [BYTE_W-1:0] ycc;
    logic [BYTE_W-1:0] pix_byte;
    logic [BYTE_W-1:0] code_byte;

    assign slot = {pix_odd, ph};
    assign yord = (fmt_q == FMT_656) ? 2'd0 : ord_q;

    // Component pick for the 4:2:2 families
    always_comb begin
        if (yord[1] ? !slot[0] : slot[0])
            ycc = y_q;
        else if (slot[1] == yord[0])
            ycc = cb_q;
        else
            ycc = cr_q;
    end

    always_comb begin
        unique case (fmt_q)
            FMT_601: pix_byte = ycc;
            FMT_656: begin
                if (ycc == 8'h00)      pix_byte = 8'h01;
                else if (ycc == 8'hFF) pix_byte = 8'hFE;
                else                   pix_byte = ycc;
            end
            FMT_RGB: begin
                if (!ph) pix_byte = {(ord_q[0] ? b_q : r_q), g_q[5:3]};
                else     pix_byte = {g_q[2:0], (ord_q[0] ? r_q : b_q)};
            end
            FMT_RAW: begin
                if (!ph) pix_byte = {{(BYTE_W-(RAW_W-BYTE_W)){1'b0}}, raw_q[RAW_W-1:BYTE_W]};
                else     pix_byte = raw_q[BYTE_W-1:0];
            end
        endcase
    end

    always_comb begin
        unique case (cnt)
            2'd0:    code_byte = 8'hFF;
            2'd1,
            2'd2:    code_byte = 8'h00;
            default: code_byte = trs_code(1'b0, 1'b0, st == ST_TRAIL);
        endcase
    end

    // Output process
    always_comb begin
        unique case (st)
            ST_IDLE:  dout = (fmt_q == FMT_656) ? (ph ? BLANK_HI : BLANK_LO) : '0;
            ST_LEAD,
            ST_TRAIL: dout = (fmt_q == FMT_656) ? code_byte : '0;
            ST_ACT:   dout = pix_byte;
        endcase
    end

endmodule

// File: rtl/vfmt_out.sv
module vfmt_out
    import vfmt_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int V_ACTIVE = 480
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_start,
    input  logic        line_start,
    input  logic        pix_valid,
    input  logic [7:0]  pix_y,
    input  logic [7:0]  pix_cb,
    input  logic [7:0]  pix_cr,
    input  logic [4:0]  pix_r,
    input  logic [5:0]  pix_g,
    input  logic [4:0]  pix_b,
    input  logic [9:0]  pix_raw,
    input  logic [1:0]  cfg_fmt,
    input  logic [1:0]  cfg_ord,
    output logic [7:0]  vid_data,
    output logic        vid_hsync,
    output logic        vid_vsync,
    output logic        vid_pclk
);

    st_e               st;
    logic [1:0]        cnt;
    logic              ph;
    logic              pix_odd;
    logic              in_frame;
    fmt_e              fmt_q;
    logic [1:0]        ord_q;
    logic [BYTE_W-1:0] y_q, cb_q, cr_q;
    logic [R_W-1:0]    r_q;
    logic [G_W-1:0]    g_q;
    logic [B_W-1:0]    b_q;
    logic [RAW_W-1:0]  raw_q;

    vfmt_seq #(.H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE)) u_seq (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
        .cfg_fmt(cfg_fmt), .cfg_ord(cfg_ord), .st(st), .cnt(cnt), .ph(ph),
        .pix_odd(pix_odd), .in_frame(in_frame), .fmt_q(fmt_q), .ord_q(ord_q)
    );

    vfmt_hold u_hold (
        .clk(clk), .rst_n(rst_n), .st(st), .pix_valid(pix_valid),
        .pix_y(pix_y), .pix_cb(pix_cb), .pix_cr(pix_cr), .pix_r(pix_r),
        .pix_g(pix_g), .pix_b(pix_b), .pix_raw(pix_raw),
        .y_q(y_q), .cb_q(cb_q), .cr_q(cr_q), .r_q(r_q), .g_q(g_q), .b_q(b_q), .raw_q(raw_q)
    );

    vfmt_bytesel u_sel (
        .st(st), .cnt(cnt), .ph(ph), .pix_odd(pix_odd), .fmt_q(fmt_q), .ord_q(ord_q),
        .y_q(y_q), .cb_q(cb_q), .cr_q(cr_q), .r_q(r_q), .g_q(g_q), .b_q(b_q),
        .raw_q(raw_q), .dout(vid_data)
    );

    assign vid_hsync = (st == ST_ACT);
    assign vid_vsync = in_frame;
    assign vid_pclk  = ~clk;

endmodule

// File: rtl/vfmt_out_chk.sv
module vfmt_out_chk
    import vfmt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] vid_data,
    input logic       vid_hsync,
    input logic       vid_vsync,
    input fmt_e       fmt_q,
    input st_e        st,
    input logic       ph
);

    assert_hsync_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vid_hsync |-> vid_vsync);

    assert_fmt_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_vsync && $past(vid_vsync)) |-> $stable(fmt_q));

    assert_data_clipped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_hsync && fmt_q == FMT_656) |-> (vid_data != 8'h00 && vid_data != 8'hFF));

    assert_blank_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!vid_hsync && fmt_q != FMT_656) |-> (vid_data == 8'h00));

    assert_raw_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_hsync && fmt_q == FMT_RAW && !ph) |-> (vid_data[7:2] == 6'd0));

    assert_idle_alternates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && $past(st) == ST_IDLE && fmt_q == FMT_656 && $stable(fmt_q))
        |-> (vid_data != $past(vid_data)));

endmodule

bind vfmt_out vfmt_out_chk i_chk (
    .clk(clk), .rst_n(rst_n), .vid_data(vid_data), .vid_hsync(vid_hsync),
    .vid_vsync(vid_vsync), .fmt_q(fmt_q), .st(st), .ph(ph)
);

// File: tb/test_vfmt_out.sv
`timescale 1ns/1ps
module test_vfmt_out;

    localparam int H = 6;
    localparam int V = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0, line_start = 1'b0, pix_valid = 1'b0;
    logic [7:0] pix_y = '0, pix_cb = '0, pix_cr = '0;
    logic [4:0] pix_r = '0, pix_b = '0;
    logic [5:0] pix_g = '0;
    logic [9:0] pix_raw = '0;
    logic [1:0] cfg_fmt = '0, cfg_ord = '0;
    logic [7:0] vid_data;
    logic       vid_hsync, vid_vsync, vid_pclk;

    int checks = 0;
    int errors = 0;

    logic [7:0] py [H];
    logic [7:0] pcb[H];
    logic [7:0] pcr[H];
    logic [4:0] pr [H];
    logic [5:0] pg [H];
    logic [4:0] pb [H];
    logic [9:0] praw[H];

    vfmt_out #(.H_ACTIVE(H), .V_ACTIVE(V)) i_vfmt_out (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
        .pix_valid(pix_valid), .pix_y(pix_y), .pix_cb(pix_cb), .pix_cr(pix_cr),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .pix_raw(pix_raw),
        .cfg_fmt(cfg_fmt), .cfg_ord(cfg_ord), .vid_data(vid_data),
        .vid_hsync(vid_hsync), .vid_vsync(vid_vsync), .vid_pclk(vid_pclk)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] clip(input logic [7:0] v);
        if (v == 8'h00) return 8'h01;
        if (v == 8'hFF) return 8'hFE;
        return v;
    endfunction

    function automatic logic [7:0] exp_pix(input int fmt, input int ord, input int k, input int half);
        int e = k & ~1;
        int s = (k & 1) * 2 + half;
        int o = (fmt == 1) ? 0 : ord;
        logic [7:0] v;
        case (fmt)
            2: begin
                if (ord[0] == 0) v = (half == 0) ? {pr[k], pg[k][5:3]} : {pg[k][2:0], pb[k]};
                else             v = (half == 0) ? {pb[k], pg[k][5:3]} : {pg[k][2:0], pr[k]};
                return v;
            end
            3: return (half == 0) ? {6'd0, praw[k][9:8]} : praw[k][7:0];
            default: begin
                case (o)
                    0: v = (s == 0) ? pcb[e] : (s == 2) ? pcr[e] : py[k];
                    1: v = (s == 0) ? pcr[e] : (s == 2) ? pcb[e] : py[k];
                    2: v = (s == 1) ? pcb[e] : (s == 3) ? pcr[e] : py[k];
                    default: v = (s == 1) ? pcr[e] : (s == 3) ? pcb[e] : py[k];
                endcase
                return (fmt == 1) ? clip(v) : v;
            end
        endcase
    endfunction

    function automatic logic [7:0] exp_gap(input int fmt, input int c, input bit tail);
        if (fmt != 1) return 8'h00;
        case (c)
            0: return 8'hFF;
            1, 2: return 8'h00;
            default: return tail ? 8'h9D : 8'h80;
        endcase
    endfunction

    task automatic drive_pix(input int k);
        pix_valid = 1'b1;
        pix_y = py[k]; pix_cb = pcb[k]; pix_cr = pcr[k];
        pix_r = pr[k]; pix_g = pg[k]; pix_b = pb[k]; pix_raw = praw[k];
    endtask

    task automatic do_line(input int fmt, input int ord, input bit last, input bit edgev);
        for (int k = 0; k < H; k++) begin
            py[k] = 8'($urandom); pcb[k] = 8'($urandom); pcr[k] = 8'($urandom);
            pr[k] = 5'($urandom); pg[k] = 6'($urandom); pb[k] = 5'($urandom);
            praw[k] = 10'($urandom);
        end
        if (edgev) begin
            py[0] = 8'h00; py[1] = 8'hFF; pcb[0] = 8'hFF; pcr[0] = 8'h00;
        end
        line_start = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            line_start = 1'b0;
            chk("R3 lead hsync", 8'(vid_hsync), 8'd0);
            chk(fmt == 1 ? "R8 lead code" : "R9 lead blank", vid_data, exp_gap(fmt, c, 1'b0));
            if (c == 3) drive_pix(0);
        end
        for (int k = 0; k < H; k++) begin
            @(negedge clk);
            pix_valid = 1'b0;
            chk("R3 active hsync", 8'(vid_hsync), 8'd1);
            chk(fmt == 0 ? "R5 byte0" : fmt == 1 ? "R8 byte0" : fmt == 2 ? "R6 byte0" : "R7 byte0",
                vid_data, exp_pix(fmt, ord, k, 0));
            @(negedge clk);
            chk("R4 active hsync", 8'(vid_hsync), 8'd1);
            chk(fmt == 0 ? "R5 byte1" : fmt == 1 ? "R8 byte1" : fmt == 2 ? "R6 byte1" : "R7 byte1",
                vid_data, exp_pix(fmt, ord, k, 1));
            if (k + 1 < H) drive_pix(k + 1);
        end
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk("R3 tail hsync", 8'(vid_hsync), 8'd0);
            chk(fmt == 1 ? "R8 tail code" : "R9 tail blank", vid_data, exp_gap(fmt, c, 1'b1));
        end
        @(negedge clk);
        chk("R10 vsync after line", 8'(vid_vsync), last ? 8'd0 : 8'd1);
        chk("R9 idle first", vid_data, fmt == 1 ? 8'h80 : 8'h00);
        @(negedge clk);
        chk("R9 idle second", vid_data, fmt == 1 ? 8'h10 : 8'h00);
    endtask

    task automatic do_frame(input int fmt, input int ord, input bit poke);
        cfg_fmt = 2'(fmt); cfg_ord = 2'(ord);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        cfg_fmt = ~2'(fmt); cfg_ord = ~2'(ord);
        chk("R2 vsync rises", 8'(vid_vsync), 8'd1);
        for (int l = 0; l < V; l++) begin
            if (poke && l == 1) begin
                frame_start = 1'b1;
                @(negedge clk);
                frame_start = 1'b0;
                chk("R2 mid-frame start ignored", 8'(vid_vsync), 8'd1);
            end
            do_line(fmt, ord, l == V - 1, l == 0);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20417));
        repeat (3) @(negedge clk);
        chk("R1 reset data", vid_data, 8'h00);
        chk("R1 reset hsync", 8'(vid_hsync), 8'd0);
        chk("R1 reset vsync", 8'(vid_vsync), 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 pclk high at clk low", 8'(vid_pclk), 8'd1);
        chk("R1 idle blank after reset", vid_data, 8'h00);
        @(posedge clk);
        #1 chk("R11 pclk low at clk high", 8'(vid_pclk), 8'd0);
        @(negedge clk);

        for (int o = 0; o < 4; o++) do_frame(0, o, o == 2);
        do_frame(2, 0, 1'b0);
        do_frame(2, 1, 1'b1);
        do_frame(3, 0, 1'b0);
        do_frame(1, 2, 1'b1);
        for (int i = 0; i < 4; i++) do_frame(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), 1'b0);

        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        for (int c = 0; c < 8; c++) begin
            chk("R10 stray line hsync", 8'(vid_hsync), 8'd0);
            chk("R10 stray line vsync", 8'(vid_vsync), 8'd0);
            @(negedge clk);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule